// File: doc/BRIEF.md
# Word Bus Interconnect with Packed Device Map

This block connects a single requester to a fixed set of word-addressed target devices. Each device's size and access mode are set by parameters at elaboration. The devices are laid out one after another from address zero with no gaps. Each device therefore starts at the sum of the sizes of all devices before it. With sizes 4, 5 and 19, the devices start at 0, 4 and 9.

For every request, the block works out which device owns the address. It subtracts that device's start address to get a local word offset. It then raises a read or write strobe on that one device only. Read data comes back the same cycle and is cut down to the bus word width.

Three kinds of request are refused, and none of them reaches any device:
- a request outside the mapped range;
- a write to a read-only device;
- a read from a write-only device.

Each refused request is reported as a one-cycle error code. Two saturating counters record how many reads and how many writes were accepted. If the mapped devices add up to more words than the address space holds, elaboration stops with an error.

Top module: `word_bus_map`

## Requirements
- R1: Device i occupies addresses from the sum of the sizes of devices 0..i-1 up to, but not including, that sum plus its own size. For an accepted access, `dev_off_o` equals the request address minus that start address.
- R2: A read or write that is accepted asserts exactly one strobe, on the owning device. With no request, no strobe is asserted.
- R3: A request at or beyond the total mapped size asserts no strobe. One cycle later it reports error code 1 (range).
- R4: A write to a read-only device (mode code 1) asserts no strobe. One cycle later it reports error code 2 (read-only).
- R5: A read from a write-only device (mode code 2) asserts no strobe. One cycle later it reports error code 3 (write-only). Writes to it and reads from read-write devices (mode code 0) are accepted.
- R6: For an accepted read, `req_rdata_o` equals the low `DATA_W` bits of the owning device's word on `dev_rdata_i`. Device i's word sits at bits [i*DEV_DW +: DEV_DW]. In every other cycle, `req_rdata_o` is zero.
- R7: `err_o` is registered. It shows a request's code on the cycle after that request and is 0 (none) in every cycle that follows a cycle with no refused request.
- R8: `rd_count_o` rises by one on the clock edge after each accepted read. It holds at its all-ones maximum.
- R9: `wr_count_o` rises by one on the clock edge after each accepted write. It holds at its all-ones maximum.
- R10: A request with both read and write asserted is handled as a write only. No read strobe is raised for it.
- R11: While `rst_ni` is low, both counters and `err_o` are zero.
- R12: `dev_wdata_o` carries `req_wdata_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_addr_i | input | ADDR_W | Bus word address |
| req_rd_i | input | 1 | Read request |
| req_wr_i | input | 1 | Write request |
| req_wdata_i | input | DATA_W | Write data |
| req_rdata_o | output | DATA_W | Read data, truncated to bus width |
| err_o | output | 2 | Error code: 0 none, 1 range, 2 read-only, 3 write-only |
| dev_rd_o | output | NUM_DEV | Per-device read strobe |
| dev_wr_o | output | NUM_DEV | Per-device write strobe |
| dev_off_o | output | ADDR_W | Local word offset inside the selected device |
| dev_wdata_o | output | DATA_W | Write data to devices |
| dev_rdata_i | input | NUM_DEV*DEV_DW | Concatenated device read words |
| rd_count_o | output | CNT_W | Saturating count of accepted reads |
| wr_count_o | output | CNT_W | Saturating count of accepted writes |

## Verification
The testbench covers the whole address space four ways: a read sweep, a repeat of that read sweep, a write sweep, and a few requests with both read and write asserted.

The read sweep checks where each device starts and ends, including the edges between devices. It also separates accepted reads from write-only refusals and from out-of-range refusals.

The write sweep checks the read-only refusals and the write-data path. It also pushes the write counter into saturation. The repeated read sweep does the same for the read counter.

The device models put non-zero upper bits on every read word. A missing truncation therefore shows up as a data mismatch.

// File: rtl/wbus_pkg.sv
package wbus_pkg;
  typedef enum logic [1:0] {
    ACC_RW = 2'd0,
    ACC_RO = 2'd1,
    ACC_WO = 2'd2
  } acc_mode_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_RANGE = 2'd1,
    ERR_RDONLY = 2'd2,
    ERR_WRONLY = 2'd3
  } bus_err_e;
endpackage

// File: rtl/wbus_addr_decode.sv
module wbus_addr_decode #(
  parameter int unsigned NUM_DEV = 3,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DEV_SIZE [NUM_DEV] = '{4, 5, 19}
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_DEV-1:0] hit_o,
  output logic [ADDR_W-1:0]  off_o,
  output logic               in_range_o
);
  function automatic int unsigned base_of(int unsigned idx);
    int unsigned s = 0;
    for (int unsigned k = 0; k < idx; k++) s += DEV_SIZE[k];
    return s;
  endfunction

  localparam int unsigned TOTAL = base_of(NUM_DEV);
  localparam longint unsigned SPACE = longint'(1) << ADDR_W;

  // setup checks
  if (ADDR_W > 30) begin : g_bad_aw
    $error("wbus_addr_decode: ADDR_W must not exceed 30");
  end
  if (longint'(TOTAL) > SPACE) begin : g_bad_total
    $error("wbus_addr_decode: device sizes exceed address space");
  end
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_size_chk
    if (DEV_SIZE[i] == 0) begin : g_zero
      $error("wbus_addr_decode: zero-sized device");
    end
  end

  logic [31:0] a32;
  assign a32 = 32'(addr_i);

  logic [ADDR_W-1:0] off_arr [NUM_DEV];

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    localparam int unsigned LO = base_of(i);
    localparam int unsigned HI = LO + DEV_SIZE[i];
    logic lo_ok;
    if (LO == 0) begin : g_first
      assign lo_ok = 1'b1;
    end else begin : g_rest
      assign lo_ok = (a32 >= LO);
    end
    assign hit_o[i]   = lo_ok && (a32 < HI);
    assign off_arr[i] = hit_o[i] ? ADDR_W'(a32 - LO) : '0;
  end

  always_comb begin
    off_o = '0;
    for (int i = 0; i < NUM_DEV; i++) off_o |= off_arr[i];
  end

  assign in_range_o = |hit_o;
endmodule

// File: rtl/wbus_access_check.sv
module wbus_access_check
  import wbus_pkg::*;
#(
  parameter int unsigned NUM_DEV = 3,
  parameter acc_mode_e   DEV_MODE [NUM_DEV] = '{ACC_RW, ACC_RO, ACC_WO}
) (
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [NUM_DEV-1:0] hit_i,
  input  logic               in_range_i,
  output bus_err_e           err_o,
  output logic               grant_rd_o,
  output logic               grant_wr_o
);
  logic [NUM_DEV-1:0] ro_mask, wo_mask;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_mask
    assign ro_mask[i] = (DEV_MODE[i] == ACC_RO);
    assign wo_mask[i] = (DEV_MODE[i] == ACC_WO);
  end

  // write takes precedence when both strobes arrive together
  always_comb begin
    err_o = ERR_NONE;
    if (rd_i || wr_i) begin
      if (!in_range_i)                     err_o = ERR_RANGE;
      else if (wr_i && |(hit_i & ro_mask)) err_o = ERR_RDONLY;
      else if (!wr_i && |(hit_i & wo_mask)) err_o = ERR_WRONLY;
    end
  end

  assign grant_wr_o = wr_i && (err_o == ERR_NONE);
  assign grant_rd_o = rd_i && !wr_i && (err_o == ERR_NONE);
endmodule

// File: rtl/wbus_sat_counter.sv
module wbus_sat_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    count_o <= '0;
    else if (inc_i && count_o != '1) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/word_bus_map.sv
module word_bus_map
  import wbus_pkg::*;
#(
  parameter int unsigned NUM_DEV = 3,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEV_DW  = 12,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned DEV_SIZE [NUM_DEV] = '{4, 5, 19},
  parameter acc_mode_e   DEV_MODE [NUM_DEV] = '{ACC_RW, ACC_RO, ACC_WO}
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic                      req_rd_i,
  input  logic                      req_wr_i,
  input  logic [DATA_W-1:0]         req_wdata_i,
  output logic [DATA_W-1:0]         req_rdata_o,
  output logic [1:0]                err_o,
  output logic [NUM_DEV-1:0]        dev_rd_o,
  output logic [NUM_DEV-1:0]        dev_wr_o,
  output logic [ADDR_W-1:0]         dev_off_o,
  output logic [DATA_W-1:0]         dev_wdata_o,
  input  logic [NUM_DEV*DEV_DW-1:0] dev_rdata_i,
  output logic [CNT_W-1:0]          rd_count_o,
  output logic [CNT_W-1:0]          wr_count_o
);
  if (DEV_DW < DATA_W) begin : g_bad_dw
    $error("word_bus_map: DEV_DW must be at least DATA_W");
  end

  logic [NUM_DEV-1:0] hit;
  logic               in_range;
  bus_err_e           err_c, err_q;
  logic               grant_rd, grant_wr;

  wbus_addr_decode #(
    .NUM_DEV (NUM_DEV),
    .ADDR_W  (ADDR_W),
    .DEV_SIZE(DEV_SIZE)
  ) u_dec (
    .addr_i    (req_addr_i),
    .hit_o     (hit),
    .off_o     (dev_off_o),
    .in_range_o(in_range)
  );

  wbus_access_check #(
    .NUM_DEV (NUM_DEV),
    .DEV_MODE(DEV_MODE)
  ) u_chk_acc (
    .rd_i      (req_rd_i),
    .wr_i      (req_wr_i),
    .hit_i     (hit),
    .in_range_i(in_range),
    .err_o     (err_c),
    .grant_rd_o(grant_rd),
    .grant_wr_o(grant_wr)
  );

  assign dev_rd_o    = grant_rd ? hit : '0;
  assign dev_wr_o    = grant_wr ? hit : '0;
  assign dev_wdata_o = req_wdata_i;

  // read return, truncated to bus width
  always_comb begin
    req_rdata_o = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (dev_rd_o[i]) req_rdata_o = dev_rdata_i[i*DEV_DW +: DATA_W];
  end

  logic unused_rdata;
  assign unused_rdata = ^dev_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= ERR_NONE;
    else         err_q <= err_c;
  end
  assign err_o = err_q;

  wbus_sat_counter #(.W(CNT_W)) u_rd_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (grant_rd),
    .count_o(rd_count_o)
  );

  wbus_sat_counter #(.W(CNT_W)) u_wr_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (grant_wr),
    .count_o(wr_count_o)
  );
endmodule

// File: rtl/wbus_checker.sv
module wbus_checker
  import wbus_pkg::*;
#(
  parameter int unsigned NUM_DEV = 3,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned DEV_SIZE [NUM_DEV] = '{4, 5, 19},
  parameter acc_mode_e   DEV_MODE [NUM_DEV] = '{ACC_RW, ACC_RO, ACC_WO}
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic               req_rd_i,
  input logic               req_wr_i,
  input logic [NUM_DEV-1:0] dev_rd_o,
  input logic [NUM_DEV-1:0] dev_wr_o,
  input logic [1:0]         err_o,
  input logic [CNT_W-1:0]   rd_count_o,
  input logic [CNT_W-1:0]   wr_count_o
);
  function automatic int unsigned total_size();
    int unsigned s = 0;
    for (int unsigned k = 0; k < NUM_DEV; k++) s += DEV_SIZE[k];
    return s;
  endfunction
  localparam int unsigned TOTAL = total_size();

  p_one_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dev_rd_o, dev_wr_o}));

  p_range_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_rd_i || req_wr_i) && (32'(req_addr_i) >= TOTAL) |=> err_o == 2'd1);

  p_err_no_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != 2'd0) |-> $past(dev_rd_o == '0 && dev_wr_o == '0));

  p_both_is_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_rd_i && req_wr_i) |-> dev_rd_o == '0);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_mode
    if (DEV_MODE[i] == ACC_RO) begin : g_ro
      p_no_ro_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dev_wr_o[i]);
    end
    if (DEV_MODE[i] == ACC_WO) begin : g_wo
      p_no_wo_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dev_rd_o[i]);
    end
  end

  p_rd_inc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dev_rd_o) && (rd_count_o != '1) |=> rd_count_o == $past(rd_count_o) + 1'b1);

  p_rd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|dev_rd_o) |=> $stable(rd_count_o));

  p_wr_inc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dev_wr_o) && (wr_count_o != '1) |=> wr_count_o == $past(wr_count_o) + 1'b1);

  p_wr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|dev_wr_o) |=> $stable(wr_count_o));
endmodule

bind word_bus_map wbus_checker #(
  .NUM_DEV (NUM_DEV),
  .ADDR_W  (ADDR_W),
  .CNT_W   (CNT_W),
  .DEV_SIZE(DEV_SIZE),
  .DEV_MODE(DEV_MODE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_addr_i(req_addr_i),
  .req_rd_i  (req_rd_i),
  .req_wr_i  (req_wr_i),
  .dev_rd_o  (dev_rd_o),
  .dev_wr_o  (dev_wr_o),
  .err_o     (err_o),
  .rd_count_o(rd_count_o),
  .wr_count_o(wr_count_o)
);

// File: tb/sim_word_bus_map.sv
module sim_word_bus_map;
  import wbus_pkg::*;

  localparam int N   = 3;
  localparam int AW  = 5;
  localparam int DW  = 8;
  localparam int DDW = 12;
  localparam int CW  = 4;
  localparam int SZ [N] = '{4, 5, 19};
  localparam int BS [N] = '{0, 4, 9};
  localparam int MD [N] = '{0, 1, 2};
  localparam int CMAX = (1 << CW) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic            rd = 1'b0, wr = 1'b0;
  logic [DW-1:0]   wdata = '0;
  logic [DW-1:0]   rdata;
  logic [1:0]      err;
  logic [N-1:0]    drd, dwr;
  logic [AW-1:0]   doff;
  logic [DW-1:0]   dwdata;
  logic [N*DDW-1:0] drdata;
  logic [CW-1:0]   rcnt, wcnt;

  int tests = 0, fails = 0;
  int exp_rc = 0, exp_wc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // device models: upper bits nonzero so truncation is visible
  always_comb begin
    for (int i = 0; i < N; i++)
      drdata[i*DDW +: DDW] = {4'(i + 9), 8'(int'(doff) * 17 + i * 5)};
  end

  word_bus_map #(
    .NUM_DEV (N), .ADDR_W(AW), .DATA_W(DW), .DEV_DW(DDW), .CNT_W(CW),
    .DEV_SIZE('{4, 5, 19}),
    .DEV_MODE('{ACC_RW, ACC_RO, ACC_WO})
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_addr_i(addr), .req_rd_i(rd), .req_wr_i(wr),
    .req_wdata_i(wdata), .req_rdata_o(rdata), .err_o(err), .dev_rd_o(drd),
    .dev_wr_o(dwr), .dev_off_o(doff), .dev_wdata_o(dwdata), .dev_rdata_i(drdata),
    .rd_count_o(rcnt), .wr_count_o(wcnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(rcnt == 0, req, int'(rcnt), 0);
    chk(wcnt == 0, req, int'(wcnt), 0);
    chk(err == 0, req, int'(err), 0);
    chk(drd == 0 && dwr == 0, req, int'({drd, dwr}), 0);
  endtask

  task automatic acc(input int a, input bit r, input bit w, input logic [DW-1:0] wd);
    int idx = -1;
    int off = 0;
    int code;
    bit g;
    logic [N-1:0] er, ew;
    logic [DW-1:0] erd;
    string tag;
    for (int i = 0; i < N; i++)
      if (a >= BS[i] && a < BS[i] + SZ[i]) begin idx = i; off = a - BS[i]; end
    if (idx < 0)                      code = 1;
    else if (w && MD[idx] == 1)       code = 2;
    else if (!w && r && MD[idx] == 2) code = 3;
    else                              code = 0;
    g  = (r || w) && code == 0;
    er = (g && !w) ? N'(1 << idx) : '0;
    ew = (g && w)  ? N'(1 << idx) : '0;
    erd = (g && !w) ? 8'(off * 17 + idx * 5) : '0;
    case (code)
      1: tag = "R3";
      2: tag = "R4";
      3: tag = "R5";
      default: tag = (r && w) ? "R10" : "R2";
    endcase

    @(negedge clk);
    chk(err == 0, "R7", int'(err), 0);
    addr = AW'(a); rd = r; wr = w; wdata = wd;
    #2;
    chk(drd == er, tag, int'(drd), int'(er));
    chk(dwr == ew, tag, int'(dwr), int'(ew));
    if (g) chk(int'(doff) == off, "R1", int'(doff), off);
    chk(rdata == erd, "R6", int'(rdata), int'(erd));
    if (w) chk(dwdata == wd, "R12", int'(dwdata), int'(wd));
    if (g && !w && exp_rc < CMAX) exp_rc++;
    if (g && w && exp_wc < CMAX) exp_wc++;

    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    chk(int'(err) == code, (code == 0) ? "R7" : tag, int'(err), code);
    chk(int'(rcnt) == exp_rc, "R8", int'(rcnt), exp_rc);
    chk(int'(wcnt) == exp_wc, "R9", int'(wcnt), exp_wc);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1;
    chk_idle("R11");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R11");

    // read sweep twice: reaches read saturation
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < (1 << AW); a++) acc(a, 1'b1, 1'b0, '0);
    // write sweep: write counter saturates
    for (int a = 0; a < (1 << AW); a++) acc(a, 1'b0, 1'b1, 8'(a ^ 8'h5A));
    // read and write together: treated as write
    acc(1, 1'b1, 1'b1, 8'hC3);
    acc(6, 1'b1, 1'b1, 8'h3C);
    acc(20, 1'b1, 1'b1, 8'h99);
    acc(30, 1'b1, 1'b1, 8'h11);

    // reset clears counters
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk_idle("R11");
    exp_rc = 0; exp_wc = 0;
    @(negedge clk);
    rst_n = 1'b1;
    acc(2, 1'b1, 1'b0, '0);
    acc(27, 1'b0, 1'b1, 8'h77);
    acc(28, 1'b0, 1'b1, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule